// File: doc/BRIEF.md
# UART Interrupt Status, Mask and Line Routing

This block holds the interrupt state of a serial port. Event pulses from the receive and transmit FIFO logic, the receive timeout counter, the modem input logic and the error detectors set bits in a sticky raw status word. A mask register chooses which raw bits may reach the outputs. The masked word is then sent to six registered interrupt lines. One combined line covers every source. Five narrower lines each cover one group: receive, transmit, receive timeout, modem status and error.

Software uses a small word-addressed register port with an address, a write strobe, write data and combinational read data. It programs the mask and reads back the raw and masked words. It acknowledges interrupts by writing ones to a clear register. A write to the transmit-data address also raises the transmit interrupt bit, because a character has been handed to the transmitter.

No data stream passes through this block, so it has no valid/ready handshake. Every pin is a plain level or strobe that is sampled on each rising clock edge. The register port is never stalled, and there is no back-pressure to respect.

Top module: `uirq_top`

## Requirements
- R1: While `rst_n` is low and after it is released, the raw status, the mask and all six interrupt outputs are 0.
- R2: A 1 on any bit of `evt_set` in a cycle sets the same raw status bit. The bit stays set until it is cleared. Bit layout: modem bits 3:0 (ring, clear-to-send, carrier detect, data-set-ready), receive bit 4, transmit bit 5, receive timeout bit 6, error bits 10:7 (framing, parity, break, overrun).
- R3: Register addresses are 0 transmit data, 1 mask, 2 raw status and 3 masked status. Reading address 1 returns the mask, address 2 returns the raw status, and address 3 returns the raw status ANDed with the mask. Address 4 is the clear register, and unused addresses read 0.
- R4: A write to address 4 clears each raw bit whose write-data bit is 1. Raw bits written as 0 keep their value.
- R5: Reading address 4 always returns 0.
- R6: Writes to address 2 and address 3 change neither the raw status nor the mask.
- R7: A write to address 0 sets raw status bit 5 (transmit).
- R8: If one bit is both set by `evt_set` and cleared by a clear write in the same cycle, the bit ends up set.
- R9: `irq_all` is high when any bit of the masked status is 1. Each output is registered and reflects the status one cycle after the status register changes.
- R10: `irq_rx` follows masked bit 4, `irq_tx` follows masked bit 5, and `irq_rtim` follows masked bit 6. `irq_modem` follows the OR of masked bits 3:0, and `irq_err` follows the OR of masked bits 10:7.
- R11: A write to address 1 updates the mask at that clock edge. The outputs follow the new mask at the next edge, with no change to the raw status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Word address of the register access |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 11 | Write data |
| reg_rdata | output | 11 | Combinational read data for `reg_addr` |
| evt_set | input | 11 | Per-bit event pulses that set raw status |
| irq_all | output | 1 | Combined interrupt line |
| irq_rx | output | 1 | Receive interrupt line |
| irq_tx | output | 1 | Transmit interrupt line |
| irq_rtim | output | 1 | Receive timeout interrupt line |
| irq_modem | output | 1 | Modem status group line |
| irq_err | output | 1 | Error group line |

## Verification
The routing is tested with single-source events, with several groups active together, and with full, empty and error-only masks. These patterns show that each output reads its own bits and only those bits. Clear writes are tested with partial bit patterns, to separate clearing the whole word from clearing only the bits written as 1. A clear is also issued in the same cycle as a set on the same bit, which shows whether set has priority. Each output is sampled both before and after its register stage, which checks the one-cycle lag. Writes to the read-only registers and reads of the clear register are checked through the read port.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int STAT_W = 11;
  localparam int NLINES = 6;
  localparam int AW     = 3;

  localparam int B_RX = 4;
  localparam int B_TX = 5;
  localparam int B_RT = 6;

  localparam logic [STAT_W-1:0] M_MODEM = 11'h00F;
  localparam logic [STAT_W-1:0] M_RX    = 11'h010;
  localparam logic [STAT_W-1:0] M_TX    = 11'h020;
  localparam logic [STAT_W-1:0] M_RT    = 11'h040;
  localparam logic [STAT_W-1:0] M_ERR   = 11'h780;
  localparam logic [STAT_W-1:0] M_ALL   = M_MODEM | M_RX | M_TX | M_RT | M_ERR;

  // line index: 0 combined, 1 rx, 2 tx, 3 timeout, 4 modem, 5 error
  localparam logic [NLINES-1:0][STAT_W-1:0] LINE_MASK =
    {M_ERR, M_MODEM, M_RT, M_TX, M_RX, M_ALL};

  typedef enum logic [AW-1:0] {
    A_TXDATA = 3'd0,
    A_MASK   = 3'd1,
    A_RAW    = 3'd2,
    A_MASKED = 3'd3,
    A_CLEAR  = 3'd4
  } addr_e;
endpackage

// File: rtl/uirq_regfile.sv
module uirq_regfile
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [STAT_W-1:0] wdata,
  input  logic [STAT_W-1:0] raw,
  output logic [STAT_W-1:0] mask,
  output logic [STAT_W-1:0] clr_vec,
  output logic              tx_set,
  output logic [STAT_W-1:0] rdata
);
  logic [STAT_W-1:0] mask_q;
  logic              hit_mask, hit_clr, hit_tx;

  always_comb begin
    hit_mask = we && (addr == A_MASK);
    hit_clr  = we && (addr == A_CLEAR);
    hit_tx   = we && (addr == A_TXDATA);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        mask_q <= '0;
    else if (hit_mask) mask_q <= wdata;
  end

  assign mask    = mask_q;
  assign clr_vec = hit_clr ? wdata : '0;
  assign tx_set  = hit_tx;

  always_comb begin
    unique case (addr)
      A_MASK:   rdata = mask_q;
      A_RAW:    rdata = raw;
      A_MASKED: rdata = raw & mask_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/uirq_status.sv
module uirq_status
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set_vec,
  input  logic [STAT_W-1:0] clr_vec,
  output logic [STAT_W-1:0] raw
);
  logic [STAT_W-1:0] raw_q;

  // set is applied after clear so it has priority on a shared bit
  always_ff @(posedge clk) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_vec) | set_vec;
  end

  assign raw = raw_q;
endmodule

// File: rtl/uirq_route.sv
module uirq_route
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] raw,
  input  logic [STAT_W-1:0] mask,
  output logic [NLINES-1:0] lines
);
  logic [STAT_W-1:0] masked;
  assign masked = raw & mask;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic line_q;
    always_ff @(posedge clk) begin
      if (!rst_n) line_q <= 1'b0;
      else        line_q <= |(masked & LINE_MASK[g]);
    end
    assign lines[g] = line_q;
  end
endmodule

// File: rtl/uirq_top.sv
module uirq_top
  import uirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     reg_addr,
  input  logic              reg_we,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  input  logic [STAT_W-1:0] evt_set,
  output logic              irq_all,
  output logic              irq_rx,
  output logic              irq_tx,
  output logic              irq_rtim,
  output logic              irq_modem,
  output logic              irq_err
);
  logic [STAT_W-1:0] raw_q, mask_q, clr_vec, set_vec;
  logic              tx_set;
  logic [NLINES-1:0] lines;

  uirq_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .we(reg_we), .wdata(reg_wdata),
    .raw(raw_q), .mask(mask_q), .clr_vec(clr_vec), .tx_set(tx_set), .rdata(reg_rdata)
  );

  always_comb begin
    set_vec = evt_set;
    set_vec[B_TX] = evt_set[B_TX] | tx_set;
  end

  uirq_status u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .raw(raw_q)
  );

  uirq_route u_route (
    .clk(clk), .rst_n(rst_n), .raw(raw_q), .mask(mask_q), .lines(lines)
  );

  assign irq_all   = lines[0];
  assign irq_rx    = lines[1];
  assign irq_tx    = lines[2];
  assign irq_rtim  = lines[3];
  assign irq_modem = lines[4];
  assign irq_err   = lines[5];
endmodule

// File: rtl/uirq_chk.sv
module uirq_chk
  import uirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     reg_addr,
  input logic              reg_we,
  input logic [STAT_W-1:0] reg_wdata,
  input logic [STAT_W-1:0] reg_rdata,
  input logic [STAT_W-1:0] evt_set,
  input logic              irq_all,
  input logic              irq_rx,
  input logic              irq_err,
  input logic [STAT_W-1:0] raw,
  input logic [STAT_W-1:0] mask
);
  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((raw & $past(evt_set)) == $past(evt_set))); // R2

  AST_CLEAR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CLEAR) |=> ((raw & $past(reg_wdata & ~evt_set)) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CLEAR && |(reg_wdata & evt_set))
      |=> ((raw & $past(reg_wdata & evt_set)) == $past(reg_wdata & evt_set))); // R8

  AST_CLEAR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CLEAR) |-> (reg_rdata == '0)); // R5

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == A_RAW || reg_addr == A_MASKED) && evt_set == '0)
      |=> (raw == $past(raw) && mask == $past(mask))); // R6

  AST_TXDATA_SETS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_TXDATA) |=> raw[B_TX]); // R7

  AST_COMBINED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_all == $past(|(raw & mask))); // R9

  AST_RX_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx == $past(raw[B_RX] & mask[B_RX])); // R10

  AST_ERR_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_err == $past(|(raw & mask & M_ERR))); // R10
endmodule

bind uirq_top uirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
  .irq_all(irq_all), .irq_rx(irq_rx), .irq_err(irq_err),
  .raw(raw_q), .mask(mask_q)
);

// File: tb/tb_uirq_top.sv
module tb_uirq_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [10:0] reg_wdata = '0;
  logic [10:0] reg_rdata;
  logic [10:0] evt_set = '0;
  logic        irq_all, irq_rx, irq_tx, irq_rtim, irq_modem, irq_err;

  always #4 clk = ~clk;

  uirq_top dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
    .irq_all(irq_all), .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_rtim(irq_rtim),
    .irq_modem(irq_modem), .irq_err(irq_err)
  );

  typedef struct {
    bit          is_irq;
    logic [10:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [10:0] m_raw = '0;
  logic [10:0] m_mask = '0;

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      item_t it;
      logic [10:0] act;
      wait (q.size() != 0);
      it = q.pop_front();
      act = it.is_irq ? {5'd0, irq_err, irq_modem, irq_rtim, irq_tx, irq_rx, irq_all}
                      : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [10:0] exp_lines(input logic [10:0] r, input logic [10:0] m);
    logic [10:0] x;
    x = r & m;
    return {5'd0, |x[10:7], |x[3:0], x[6], x[5], x[4], |x};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [10:0] e, input string tag);
    item_t it;
    reg_addr = a;
    #1;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    q.push_back(it);
    #1;
  endtask

  task automatic chk_irq(input logic [10:0] e, input string tag);
    item_t it;
    it.is_irq = 1'b1; it.exp = e; it.tag = tag;
    q.push_back(it);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [10:0] d, input logic [10:0] s);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; evt_set = s;
    if (a == 3'd1) m_mask = d;
    if (a == 3'd4) m_raw = m_raw & ~d;
    if (a == 3'd0) m_raw[5] = 1'b1;
    m_raw = m_raw | s;
    tick();
    reg_we = 1'b0; evt_set = '0;
  endtask

  task automatic pulse(input logic [10:0] s);
    evt_set = s;
    m_raw = m_raw | s;
    tick();
    evt_set = '0;
  endtask

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk_rd(3'd1, 11'h000, "R1 mask after reset");
    chk_rd(3'd2, 11'h000, "R1 raw after reset");
    chk_irq(11'h000, "R1 lines after reset");
    rst_n = 1'b1;
    tick();
    chk_irq(11'h000, "R1 lines after release");

    // R2 receive event, mask closed
    pulse(11'h010);
    chk_rd(3'd2, m_raw, "R2 raw holds receive bit");
    chk_rd(3'd3, 11'h000, "R3 masked is zero with closed mask");
    tick();
    chk_irq(11'h000, "R9 no line with closed mask");

    // R11 open mask: raw unchanged, lines follow one edge later
    wr(3'd1, 11'h7FF, '0);
    chk_irq(11'h000, "R9 line lags mask write by one edge");
    chk_rd(3'd1, 11'h7FF, "R3 mask readback");
    tick();
    chk_irq(exp_lines(m_raw, m_mask), "R11 lines after mask write");
    chk_rd(3'd3, m_raw & m_mask, "R3 masked status");

    // R6 writes to read-only registers ignored
    wr(3'd2, 11'h7FF, '0);
    wr(3'd3, 11'h000, '0);
    chk_rd(3'd2, m_raw, "R6 raw after writes to status registers");
    chk_rd(3'd1, 11'h7FF, "R6 mask after writes to status registers");

    // R4 / R5 clear
    chk_rd(3'd4, 11'h000, "R5 clear register reads zero");
    wr(3'd4, 11'h010, '0);
    chk_rd(3'd2, 11'h000, "R4 receive bit cleared");
    tick();
    chk_irq(11'h000, "R9 lines drop after clear");

    // R7 transmit data write
    wr(3'd0, 11'h041, '0);
    chk_rd(3'd2, 11'h020, "R7 tx bit set by data write");
    tick();
    chk_irq(exp_lines(m_raw, m_mask), "R10 tx line only");

    // R10 several groups together
    pulse(11'h182);
    pulse(11'h040);
    chk_irq(exp_lines(11'h0A2 | 11'h100, m_mask) & 11'h03F, "R9 previous status before register");
    tick();
    chk_irq(exp_lines(m_raw, m_mask), "R10 group lines with many sources");
    chk_rd(3'd2, 11'h1E2, "R2 raw accumulates");

    // R11 error-only mask
    wr(3'd1, 11'h780, '0);
    tick();
    chk_irq(exp_lines(m_raw, m_mask), "R11 error-only mask");
    chk_rd(3'd3, 11'h180, "R3 masked under error mask");

    // R4 partial clear keeps other bits
    wr(3'd4, 11'h080, '0);
    chk_rd(3'd2, 11'h162, "R4 partial clear");
    tick();
    chk_irq(exp_lines(m_raw, m_mask), "R10 error line from remaining bit");

    // R8 set beats clear
    wr(3'd4, 11'h7FF, 11'h400);
    chk_rd(3'd2, 11'h400, "R8 set wins over clear");
    tick();
    chk_irq(exp_lines(m_raw, m_mask), "R8 error line stays high");

    // R1 reset mid-run
    rst_n = 1'b0;
    tick();
    m_raw = '0; m_mask = '0;
    chk_rd(3'd2, 11'h000, "R1 raw cleared by reset");
    chk_rd(3'd1, 11'h000, "R1 mask cleared by reset");
    chk_irq(11'h000, "R1 lines cleared by reset");
    rst_n = 1'b1;
    tick();

    done = 1'b1;
    #20;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule